// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital side of a dual-slope integrating analog-to-digital converter. On a start request it first closes the integrator-reset switch for a single clock. It then connects the held input to the integrator for a fixed number of clocks, the run-up. After that it switches the integrator over to the reference of opposite polarity and counts clocks, the run-down, until the comparator reports that the integrator output has crossed zero. The run-down count is the conversion result. Because both slopes pass through the same integrator, the count does not depend on the integrator's time constant. No calibration is therefore needed.

The run-up length is a parameter. It can be set to a whole multiple of an interference period so that the integration rejects that frequency and its harmonics. The run-down is capped at 2^RES_W clocks. A conversion that has not crossed by then returns a saturated code and raises an overflow flag. The input must stay constant for the whole conversion. Completion is marked by a one-clock pulse. The result and the flag then hold until the next conversion completes.

Top module: `dsadc_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, done_o, ovf_o and the three switch outputs are 0 and result_o is 0.
- R2: When start_i is high at a clock edge while busy_o is low, busy_o and int_clr_o go high after that edge. int_clr_o stays high for exactly one cycle and is followed directly by the run-up.
- R3: The run-up (sel_in_o high) lasts exactly T1_CYCLES cycles. It is followed directly by the run-down (sel_ref_o high).
- R4: The run-down counter starts at 0 in the first run-down cycle. At the first clock edge of the run-down where cmp_i is sampled high, result_o takes the count of run-down cycles that came before that edge. This is 0 if cmp_i is high in the first run-down cycle. ovf_o is cleared at the same edge.
- R5: If cmp_i stays low for all 2^RES_W run-down cycles, the run-down ends after those cycles. result_o becomes all ones and ovf_o becomes 1.
- R6: done_o is high for exactly one cycle, in the cycle after the last run-down cycle, and busy_o is low in that cycle. busy_o is high for 2 + T1_CYCLES + result_o cycles for a normal conversion, and for 1 + T1_CYCLES + 2^RES_W cycles on overflow.
- R7: start_i has no effect while busy_o is high. The sequence timing and the result are unchanged.
- R8: result_o and ovf_o change only at the edge that raises done_o, and otherwise hold their values, including during the next conversion.
- R9: At most one of int_clr_o, sel_in_o and sel_ref_o is high at a time, and all three are low while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | Comparator: 1 once the integrator has crossed zero |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| int_clr_o | output | 1 | Integrator reset switch |
| sel_in_o | output | 1 | Integrate-input switch (run-up) |
| sel_ref_o | output | 1 | Integrate-reference switch (run-down) |
| result_o | output | RES_W | Run-down count |
| ovf_o | output | 1 | Run-down reached its limit without a crossing |

## Verification
An integrator model in the bench ramps up with the input value during run-up and ramps down with a fixed reference slope during run-down. The comparator trips once the model goes below zero. Input codes 0, 1, a mid-scale value and full-scale 255 check the count alignment at both ends and show that a crossing in the last possible cycle is not reported as an overflow. Codes 256 and 400 drive the run-down into saturation. Repeating one code with the model's slopes scaled up sevenfold shows that the result follows only the slope ratio and not the time constant. A start pulse in the middle of a conversion and a second conversion started after a completed one separate start masking from result holding.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CLEAR,
    PH_RUNUP,
    PH_RUNDOWN
  } phase_e;
endpackage

// File: rtl/dsadc_count.sv
module dsadc_count #(
  parameter int W    = 8,
  parameter int LAST = 255
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == W'(LAST));
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   cmp_i,
  input  logic   runup_last_i,
  input  logic   rundown_last_i,
  output phase_e phase_o,
  output logic   finish_o,
  output logic   sat_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:    if (start_i) phase_d = PH_CLEAR;
      PH_CLEAR:   phase_d = PH_RUNUP;
      PH_RUNUP:   if (runup_last_i) phase_d = PH_RUNDOWN;
      PH_RUNDOWN: if (cmp_i || rundown_last_i) phase_d = PH_IDLE;
      default:    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o  = phase_q;
  assign finish_o = (phase_q == PH_RUNDOWN) && (cmp_i || rundown_last_i);
  // a crossing in the final cycle still counts as a valid code
  assign sat_o    = (phase_q == PH_RUNDOWN) && !cmp_i && rundown_last_i;
endmodule

// File: rtl/dsadc_capture.sv
module dsadc_capture #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         finish_i,
  input  logic         sat_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] result_o,
  output logic         ovf_o,
  output logic         done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      ovf_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (finish_i) begin
        result_o <= sat_i ? '1 : cnt_i;
        ovf_o    <= sat_i;
      end
    end
  end
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int RES_W     = 8,
  parameter int T1_CYCLES = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             int_clr_o,
  output logic             sel_in_o,
  output logic             sel_ref_o,
  output logic [RES_W-1:0] result_o,
  output logic             ovf_o
);
  localparam int TW        = (T1_CYCLES > 1) ? $clog2(T1_CYCLES) : 1;
  localparam int MEAS_LAST = (1 << RES_W) - 1;

  phase_e             phase;
  logic               finish, sat;
  logic               runup_last, rundown_last;
  logic [TW-1:0]      runup_cnt;
  logic [RES_W-1:0]   rundown_cnt;

  dsadc_seq u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .cmp_i          (cmp_i),
    .runup_last_i   (runup_last),
    .rundown_last_i (rundown_last),
    .phase_o        (phase),
    .finish_o       (finish),
    .sat_o          (sat)
  );

  dsadc_count #(.W(TW), .LAST(T1_CYCLES - 1)) u_runup_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (phase != PH_RUNUP),
    .en_i   (phase == PH_RUNUP),
    .cnt_o  (runup_cnt),
    .last_o (runup_last)
  );

  dsadc_count #(.W(RES_W), .LAST(MEAS_LAST)) u_rundown_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (phase != PH_RUNDOWN),
    .en_i   (phase == PH_RUNDOWN),
    .cnt_o  (rundown_cnt),
    .last_o (rundown_last)
  );

  dsadc_capture #(.W(RES_W)) u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .finish_i (finish),
    .sat_i    (sat),
    .cnt_i    (rundown_cnt),
    .result_o (result_o),
    .ovf_o    (ovf_o),
    .done_o   (done_o)
  );

  assign busy_o    = (phase != PH_IDLE);
  assign int_clr_o = (phase == PH_CLEAR);
  assign sel_in_o  = (phase == PH_RUNUP);
  assign sel_ref_o = (phase == PH_RUNDOWN);

  logic unused_runup;
  assign unused_runup = ^runup_cnt;
endmodule

// File: rtl/dsadc_ctrl_chk.sv
module dsadc_ctrl_chk #(
  parameter int RES_W     = 8,
  parameter int T1_CYCLES = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             int_clr_o,
  input logic             sel_in_o,
  input logic             sel_ref_o,
  input logic [RES_W-1:0] result_o,
  input logic             ovf_o
);
  logic [31:0] up_len, dn_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_len <= '0;
      dn_len <= '0;
    end else begin
      up_len <= sel_in_o  ? up_len + 1 : '0;
      dn_len <= sel_ref_o ? dn_len + 1 : '0;
    end
  end

  a_r2_start_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (int_clr_o && busy_o));
  a_r2_clear_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_clr_o |=> (!int_clr_o && sel_in_o));
  a_r3_runup_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_in_o) |-> (up_len == T1_CYCLES && sel_ref_o));
  a_r5_rundown_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_len <= (1 << RES_W));
  a_r5_ovf_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (result_o == {RES_W{1'b1}}));
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $fell(sel_ref_o)));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(ovf_o)));
  a_r9_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({int_clr_o, sel_in_o, sel_ref_o}));
  a_r9_idle_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(int_clr_o || sel_in_o || sel_ref_o));
endmodule

bind dsadc_ctrl dsadc_ctrl_chk #(.RES_W(RES_W), .T1_CYCLES(T1_CYCLES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .int_clr_o (int_clr_o),
  .sel_in_o  (sel_in_o),
  .sel_ref_o (sel_ref_o),
  .result_o  (result_o),
  .ovf_o     (ovf_o)
);

// File: tb/dsadc_ctrl_bench.sv
module dsadc_ctrl_bench;
  localparam int RES_W = 8;
  localparam int T1    = 256;
  localparam int FULL  = 1 << RES_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic cmp_i;
  logic busy_o, done_o, int_clr_o, sel_in_o, sel_ref_o, ovf_o;
  logic [RES_W-1:0] result_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  longint acc = 0;
  longint m_vin = 0;
  longint m_gain = 1;

  always #5 clk_i = ~clk_i;

  dsadc_ctrl #(.RES_W(RES_W), .T1_CYCLES(T1)) u_dsadc_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cmp_i(cmp_i),
    .busy_o(busy_o), .done_o(done_o), .int_clr_o(int_clr_o),
    .sel_in_o(sel_in_o), .sel_ref_o(sel_ref_o),
    .result_o(result_o), .ovf_o(ovf_o)
  );

  // integrator model: input slope vin*g during run-up, reference slope FULL*g down
  always @(negedge clk_i) begin
    if (int_clr_o)      acc <= 0;
    else if (sel_in_o)  acc <= acc + m_vin * m_gain * FULL / T1;
    else if (sel_ref_o) acc <= acc - FULL * m_gain;
  end
  assign cmp_i = sel_ref_o && (acc < 0);

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung act=%0d exp<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // runs one conversion; optional stray start pulse at a given busy cycle
  task automatic convert(input longint vin, input longint gain, input int stray_at,
                         output int busy_n, output int done_n, output int clr_n,
                         output int up_n, output int dn_n);
    int guard;
    m_vin = vin;
    m_gain = gain;
    busy_n = 0; done_n = 0; clr_n = 0; up_n = 0; dn_n = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    guard = 0;
    while (guard < 2000) begin
      if (busy_o)    busy_n++;
      if (done_o)    done_n++;
      if (int_clr_o) clr_n++;
      if (sel_in_o)  up_n++;
      if (sel_ref_o) dn_n++;
      if (done_o) break;
      start_i = (busy_n == stray_at);
      @(negedge clk_i);
      guard++;
    end
    start_i = 1'b0;
    @(negedge clk_i);
    if (done_o) done_n++;
  endtask

  task automatic t_reset();
    #1;
    chk(!busy_o && !done_o && !ovf_o, "R1 flags in reset", {busy_o, done_o, ovf_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({int_clr_o, sel_in_o, sel_ref_o} == 3'b000, "R1 switches after reset",
        {int_clr_o, sel_in_o, sel_ref_o}, 0);
    chk(result_o == 0 && !busy_o, "R1 result after reset", result_o, 0);
  endtask

  task automatic t_code(input longint vin, input longint gain, input string tag);
    int b, d, c, u, n;
    convert(vin, gain, -1, b, d, c, u, n);
    chk(result_o == vin, {tag, " R4 result"}, result_o, vin);
    chk(!ovf_o, {tag, " R4 ovf clear"}, ovf_o, 0);
    chk(c == 1, {tag, " R2 clear cycles"}, c, 1);
    chk(u == T1, {tag, " R3 runup cycles"}, u, T1);
    chk(n == vin + 1, {tag, " R4 rundown cycles"}, n, vin + 1);
    chk(b == 2 + T1 + vin, {tag, " R6 busy cycles"}, b, 2 + T1 + vin);
    chk(d == 1, {tag, " R6 done pulse"}, d, 1);
  endtask

  task automatic t_overflow(input longint vin);
    int b, d, c, u, n;
    convert(vin, 1, -1, b, d, c, u, n);
    chk(result_o == FULL - 1, "R5 saturated result", result_o, FULL - 1);
    chk(ovf_o, "R5 ovf flag", ovf_o, 1);
    chk(n == FULL, "R5 rundown capped", n, FULL);
    chk(b == 1 + T1 + FULL, "R6 busy on overflow", b, 1 + T1 + FULL);
    chk(d == 1, "R6 done pulse on overflow", d, 1);
  endtask

  task automatic t_stray_start();
    int b, d, c, u, n;
    convert(77, 1, 100, b, d, c, u, n);
    chk(result_o == 77, "R7 result with stray start", result_o, 77);
    chk(b == 2 + T1 + 77, "R7 busy unchanged", b, 2 + T1 + 77);
    chk(c == 1, "R7 no extra clear", c, 1);
    repeat (3) @(negedge clk_i);
    chk(!busy_o, "R7 no restart", busy_o, 0);
  endtask

  task automatic t_hold();
    int held;
    repeat (20) @(negedge clk_i);
    chk(result_o == 42, "R8 result idle hold", result_o, 42);
    m_vin = 9;
    m_gain = 1;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    held = 1;
    while (!done_o) begin
      if (result_o != 42) held = 0;
      @(negedge clk_i);
    end
    chk(held == 1, "R8 result held during next run", held, 1);
    chk(result_o == 9, "R8 new result on done", result_o, 9);
  endtask

  initial begin
    t_reset();
    t_code(0, 1, "zero");
    t_code(1, 1, "one");
    t_code(100, 1, "mid");
    t_code(255, 1, "full");
    t_code(100, 7, "gain7");
    t_overflow(256);
    t_code(3, 1, "after-ovf");
    t_overflow(400);
    t_stray_start();
    t_code(42, 1, "pre-hold");
    t_hold();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule